// File: doc/BRIEF.md
# Addressable Bit Latch with Decoder Modes

This block holds a small bank of single-bit outputs, one per address, and writes one bit at a time from a shared data input. Two active-low controls, a write enable and a clear, together pick one of four operating modes. In the first, the addressed bit is written and the others are kept. In the second, everything is held. In the third, the block works as a 1-of-N active-high decoder that forces every non-addressed output low. In the fourth, all outputs are cleared. Typical uses are a serial-to-parallel port, built by walking the address while writing, and a one-hot select decoder.

The block is a synchronous equivalent of a transparent latch on a system clock. The outputs are formed combinationally from an internal state register, the mode, the address and the data input. An addressed bit therefore follows the data in the same cycle while writing is enabled. The register takes the output value on every clock edge, so the level seen in the last enabled cycle is what remains stored once the enable is released.

Top module: `bit_addr_latch`

## Requirements
- R1: Address value k selects output bit q[k]. sel[0] is the least significant address bit, and k ranges over 0 to N_OUT-1.
- R2: The mode comes from {wr_en_n, clr_n}: 01 is write, 11 is hold, 00 is decode, 10 is clear.
- R3: In write mode, the addressed output equals din in the same cycle.
- R4: In write mode, every non-addressed output keeps its value from the previous cycle.
- R5: After write mode ends in hold, the addressed bit keeps the din level of the last enabled cycle.
- R6: In hold mode, all outputs keep their previous values, whatever din and sel do.
- R7: In decode mode, the addressed output equals din and all other outputs are 0, in the same cycle.
- R8: Entering hold from decode mode keeps the decoder pattern.
- R9: In clear mode, all outputs are 0 regardless of din and sel, and the stored state becomes 0.
- R10: The synchronous active-high rst clears the stored state. After rst, hold mode shows all zeros.
- R11: Changing sel while in hold mode disturbs no stored bit. A later write touches only the new address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset of the stored state |
| wr_en_n | input | 1 | Active-low write enable |
| clr_n | input | 1 | Active-low clear; selects decode or clear mode when low |
| sel | input | ADDR_W | Bit address, LSB first |
| din | input | 1 | Data bit |
| q | output | N_OUT | Output bits |

## Verification
The hardest situation to reach is a hold period in which the address moves across several bits while din toggles. A correct design shows nothing changing there, so a fault only becomes visible when a later write lands on the new address and the old bits are checked as untouched. The directed sequences set up exactly this: a write, then address and data motion in hold, then a second write with a fixed expected pattern. The random phase draws modes with biased weights so that runs of decode mode followed by hold, which leave a decoder pattern stored, come up often.

// File: rtl/lat_pkg.sv
package lat_pkg;
  typedef enum logic [1:0] {
    MODE_WRITE = 2'd0,
    MODE_HOLD  = 2'd1,
    MODE_DEC   = 2'd2,
    MODE_CLEAR = 2'd3
  } lat_mode_e;
endpackage

// File: rtl/lat_mode_dec.sv
module lat_mode_dec (
  input  logic              wr_en_n,
  input  logic              clr_n,
  output lat_pkg::lat_mode_e mode
);
  always_comb begin
    unique case ({wr_en_n, clr_n})
      2'b01:   mode = lat_pkg::MODE_WRITE;
      2'b11:   mode = lat_pkg::MODE_HOLD;
      2'b00:   mode = lat_pkg::MODE_DEC;
      default: mode = lat_pkg::MODE_CLEAR;
    endcase
  end
endmodule

// File: rtl/lat_addr_dec.sv
module lat_addr_dec #(
  parameter int ADDR_W = 3,
  localparam int N_OUT = 1 << ADDR_W
) (
  input  logic [ADDR_W-1:0] sel,
  output logic [N_OUT-1:0]  hit
);
  for (genvar i = 0; i < N_OUT; i++) begin : g_hit
    assign hit[i] = (sel == ADDR_W'(i));
  end
endmodule

// File: rtl/lat_bit_cell.sv
module lat_bit_cell (
  input  lat_pkg::lat_mode_e mode,
  input  logic               hit,
  input  logic               din,
  input  logic               held,
  output logic               nxt
);
  always_comb begin
    unique case (mode)
      lat_pkg::MODE_WRITE: nxt = hit ? din : held;
      lat_pkg::MODE_HOLD:  nxt = held;
      lat_pkg::MODE_DEC:   nxt = hit & din;
      default:             nxt = 1'b0;
    endcase
  end
endmodule

// File: rtl/bit_addr_latch.sv
module bit_addr_latch #(
  parameter int ADDR_W = 3,
  localparam int N_OUT = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_n,
  input  logic              clr_n,
  input  logic [ADDR_W-1:0] sel,
  input  logic              din,
  output logic [N_OUT-1:0]  q
);
  lat_pkg::lat_mode_e mode;
  logic [N_OUT-1:0]   hit;
  logic [N_OUT-1:0]   state_q;
  logic [N_OUT-1:0]   state_nxt;

  lat_mode_dec u_mode (
    .wr_en_n (wr_en_n),
    .clr_n   (clr_n),
    .mode    (mode)
  );

  lat_addr_dec #(.ADDR_W(ADDR_W)) u_addr (
    .sel (sel),
    .hit (hit)
  );

  for (genvar i = 0; i < N_OUT; i++) begin : g_cell
    lat_bit_cell u_cell (
      .mode (mode),
      .hit  (hit[i]),
      .din  (din),
      .held (state_q[i]),
      .nxt  (state_nxt[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= '0;
    else     state_q <= state_nxt;
  end

  assign q = state_nxt;
endmodule

// File: rtl/bit_addr_latch_chk.sv
module bit_addr_latch_chk #(
  parameter int ADDR_W = 3,
  localparam int N_OUT = 1 << ADDR_W
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en_n,
  input logic              clr_n,
  input logic [ADDR_W-1:0] sel,
  input logic              din,
  input logic [N_OUT-1:0]  q
);
  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  // R3
  write_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_en_n && clr_n) |-> (q[sel] == din));

  // R6
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && wr_en_n && clr_n) |-> $stable(q));

  // R7
  dec_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_en_n && !clr_n) |-> ($onehot0(q) && (q[sel] == din)));

  // R9
  clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en_n && !clr_n) |-> (q == '0));

  // R10
  after_rst_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (!armed && wr_en_n && clr_n) |-> (q == '0));

  // R4
  write_others_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && !wr_en_n && clr_n) |-> ($countones(q ^ $past(q)) <= 1));
endmodule

bind bit_addr_latch bit_addr_latch_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_en_n (wr_en_n),
  .clr_n   (clr_n),
  .sel     (sel),
  .din     (din),
  .q       (q)
);

// File: tb/bit_addr_latch_test.sv
`timescale 1ns/1ps
module bit_addr_latch_test;
  localparam int AW = 3;
  localparam int NO = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en_n = 1'b1;
  logic          clr_n = 1'b1;
  logic [AW-1:0] sel = '0;
  logic          din = 1'b0;
  logic [NO-1:0] q;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [NO-1:0] model = '0;

  always #2.5 clk = ~clk;

  bit_addr_latch #(.ADDR_W(AW)) uut (
    .clk(clk), .rst(rst), .wr_en_n(wr_en_n), .clr_n(clr_n),
    .sel(sel), .din(din), .q(q)
  );

  // R2: mode from {wr_en_n, clr_n}
  function automatic logic [NO-1:0] expect_q(input logic [NO-1:0] st,
      input logic e, input logic c, input logic [AW-1:0] a, input logic d);
    logic [NO-1:0] r;
    r = st;
    case ({e, c})
      2'b01: r[a] = d;
      2'b11: r = st;
      2'b00: begin r = '0; r[a] = d; end
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic string mode_tag(input logic e, input logic c);
    case ({e, c})
      2'b01: return "R3/R4 write";
      2'b11: return "R6 hold";
      2'b00: return "R7 decode";
      default: return "R9 clear";
    endcase
  endfunction

  task automatic check(input logic [NO-1:0] exp, input string tag);
    checks++;
    if (q !== exp) begin
      errors++;
      $display("FAIL %s: q=%h expected=%h", tag, q, exp);
    end
  endtask

  // drive at negedge, check mid-low phase, update model at posedge
  task automatic step(input logic e, input logic c, input logic [AW-1:0] a, input logic d);
    logic [NO-1:0] exp;
    @(negedge clk);
    wr_en_n = e; clr_n = c; sel = a; din = d;
    #1;
    exp = expect_q(model, e, c, a, d);
    check(exp, mode_tag(e, c));
    @(posedge clk);
    model = exp;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; wr_en_n = 1'b1; clr_n = 1'b1;
    @(posedge clk);
    model = '0;
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R10 reset state
    check('0, "R10 reset state");

    // R1 and R5: one bit per address, then hold
    for (int k = 0; k < NO; k++) begin
      do_reset();
      step(1'b0, 1'b1, AW'(k), 1'b1);
      step(1'b1, 1'b1, AW'(k + 3), 1'b0);
      check(NO'(1) << k, "R1 address map");
      check(NO'(1) << k, "R5 retained after write");
    end

    // R5: last enabled level is kept
    do_reset();
    step(1'b0, 1'b1, AW'(4), 1'b1);
    step(1'b0, 1'b1, AW'(4), 1'b0);
    step(1'b0, 1'b1, AW'(4), 1'b1);
    step(1'b1, 1'b1, AW'(0), 1'b0);
    check(NO'(1) << 4, "R5 last level kept");

    // R11: address motion during hold
    do_reset();
    step(1'b0, 1'b1, AW'(2), 1'b1);
    step(1'b1, 1'b1, AW'(5), 1'b1);
    step(1'b1, 1'b1, AW'(6), 1'b0);
    step(1'b1, 1'b1, AW'(1), 1'b1);
    check(NO'(1) << 2, "R11 hold with address motion");
    step(1'b0, 1'b1, AW'(6), 1'b1);
    step(1'b1, 1'b1, AW'(6), 1'b1);
    check((NO'(1) << 2) | (NO'(1) << 6), "R11 write after address change");

    // R7 and R8: decode then hold keeps the pattern
    for (int k = 0; k < NO; k++) begin
      step(1'b0, 1'b1, AW'((k + 1) % NO), 1'b1);
      step(1'b0, 1'b0, AW'(k), 1'b1);
      step(1'b1, 1'b1, AW'(k + 2), 1'b0);
      check(NO'(1) << k, "R8 decode pattern held");
    end
    step(1'b0, 1'b0, AW'(3), 1'b0);
    step(1'b1, 1'b1, AW'(3), 1'b1);
    check('0, "R7 decode with din low");

    // R9: clear mode
    step(1'b0, 1'b1, AW'(7), 1'b1);
    step(1'b1, 1'b0, AW'(7), 1'b1);
    step(1'b1, 1'b1, AW'(7), 1'b1);
    check('0, "R9 clear wipes state");

    // R10: rst in the middle of traffic
    step(1'b0, 1'b1, AW'(1), 1'b1);
    do_reset();
    #1;
    check('0, "R10 rst clears stored bits");

    // random traffic, biased modes
    for (int n = 0; n < 3000; n++) begin
      int r;
      logic e, c;
      r = int'($urandom % 8);
      if (r < 3)      begin e = 1'b0; c = 1'b1; end
      else if (r < 5) begin e = 1'b1; c = 1'b1; end
      else if (r < 7) begin e = 1'b0; c = 1'b0; end
      else            begin e = 1'b1; c = 1'b0; end
      step(e, c, AW'($urandom), 1'($urandom));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule